// File: doc/BRIEF.md
# I2C Clock Phase and Data Hold Timer

This block times the clock of an I2C master. Software loads two pairs of clock counts (one pair for standard speed, one for fast speed) and a data hold count while the controller is switched off. A two-bit speed field picks which pair is in force. The bit engine of the master asks for a clock-low phase or a clock-high phase. The block drives or releases SCL for the programmed number of reference clocks, then reports the end of the phase with a one-cycle strobe. During a high phase it waits for any slave that holds the clock low. Each high phase runs three reference clocks longer than its programmed count and each low phase one clock longer, because the counts are written with that overhead taken off.

The block also owns the SDA output enable. The bit engine states the SDA level it wants at any time. The block defers that change after each falling SCL edge until the programmed hold time has run out. At all other times it passes the request on one cycle later. Both outputs are output enables for open-drain pads: a 1 pulls the line low.

Top module: `scl_timer`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `low_done` and `high_done` are 0, the timer rests in the clock-high idle state, and all five count registers hold 0.
- R2: A write with `ctl_on` = 0 loads `wr_data` into the register at `wr_addr`. Address 0 holds the standard high count, 1 the standard low count, 2 the fast high count, 3 the fast low count and 4 the SDA hold count.
- R3: A write made while `ctl_on` = 1 leaves every register unchanged.
- R4: `req_low` is accepted in the clock-high idle state. At that clock edge `scl_oe` goes to 1. `low_done` pulses for one cycle exactly L+1 cycles later, where L is the selected effective low count. `scl_oe` then stays 1 until a high request is accepted.
- R5: `req_high` is accepted in the clock-low idle state. At that clock edge `scl_oe` goes to 0. `high_done` pulses for one cycle after H+3 clock edges at which `scl_in` was sampled high, where H is the selected effective high count.
- R6: Clock edges at which `scl_in` is sampled low during a high phase do not count towards its length, so a slave holding SCL low lengthens the phase by the number of such edges.
- R7: A count register holding 0 acts as a count of 1. The shortest low phase is therefore 2 cycles and the shortest high phase 4 cycles.
- R8: `speed_sel` = 2'b01 selects the standard pair. The values 2'b10, 2'b00 and 2'b11 all select the fast pair. The selection is taken when a phase request is accepted.
- R9: With hold count D, `sda_oe` keeps its value at the edge where `scl_oe` rises and for the following D edges. It first takes the level of `sda_req` at the edge D+1 cycles after SCL was driven low.
- R10: Outside a hold window, `sda_oe` follows `sda_req` with one cycle of delay.
- R11: `req_low` has no effect unless the timer rests in the clock-high idle state, and `req_high` has no effect unless it rests in the clock-low idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_on | input | 1 | Controller enabled; blocks register writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 to 4) |
| wr_data | input | 16 | Register write data |
| speed_sel | input | 2 | Speed field: 01 standard, any other value fast |
| req_low | input | 1 | Bit engine asks for a clock-low phase |
| req_high | input | 1 | Bit engine asks for a clock-high phase |
| sda_req | input | 1 | SDA drive level wanted by the bit engine |
| scl_in | input | 1 | SCL level read back from the pad |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| low_done | output | 1 | One-cycle strobe at the end of a low phase |
| high_done | output | 1 | One-cycle strobe at the end of a high phase |

## Verification
The end of the low phase and the end of the SDA hold window can land on the same clock edge. A second case lets the strobe of one phase meet a request for the wrong phase. The bench provokes the first case directly by setting the hold count to one less than the low phase length. Random runs also produce it whenever their counts happen to line up. In every run the bench records, cycle by cycle, when `low_done` first rises and when `sda_oe` first changes. It compares each against its own value computed from the programmed counts, so a coincidence must not delay, drop or merge either event.

// File: rtl/scl_timer_pkg.sv
// Shared definitions for the SCL timer: phase states, speed codes,
// register addresses and the fixed phase overheads.
package scl_timer_pkg;

    typedef enum logic [1:0] {
        PH_PARK_HI = 2'd0,
        PH_LOW     = 2'd1,
        PH_PARK_LO = 2'd2,
        PH_HIGH    = 2'd3
    } phase_t;

    localparam logic [1:0] SPD_STD = 2'b01;

    localparam int HI_EXTRA  = 3;
    localparam int LO_EXTRA  = 1;

    localparam int A_STD_HI  = 0;
    localparam int A_STD_LO  = 1;
    localparam int A_FAST_HI = 2;
    localparam int A_FAST_LO = 3;
    localparam int A_HOLD    = 4;
    localparam int NUM_REGS  = 5;

endpackage

// File: rtl/scl_cfg_regs.sv
// Count register file and speed selection.
// Holds the four clock counts and the SDA hold count. Accepts writes only
// while the controller is off. Presents the phase lengths of the selected
// speed, with zero counts clamped to one and the fixed overheads added.
// Assumes wr_addr values above the last register are simply not decoded.
module scl_cfg_regs
    import scl_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int LEN_W  = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_on,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        speed_sel,
    output logic [LEN_W-1:0]  hi_len,
    output logic [LEN_W-1:0]  lo_len,
    output logic [CNT_W-1:0]  hold_val
);

    logic [CNT_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [CNT_W-1:0] q;
        // One count register: loads only when addressed and the controller is off.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && !ctl_on && wr_addr == ADDR_W'(g)) begin
                q <= wr_data;
            end
        end
        assign regs_q[g] = q;
    end

    logic             is_std;
    logic [CNT_W-1:0] hi_raw, lo_raw, hi_eff, lo_eff;

    // Pick the pair for the current speed and clamp zero counts to one.
    always_comb begin
        is_std = (speed_sel == SPD_STD);
        hi_raw = is_std ? regs_q[A_STD_HI] : regs_q[A_FAST_HI];
        lo_raw = is_std ? regs_q[A_STD_LO] : regs_q[A_FAST_LO];
        hi_eff = (hi_raw == '0) ? CNT_W'(1) : hi_raw;
        lo_eff = (lo_raw == '0) ? CNT_W'(1) : lo_raw;
        hi_len = LEN_W'(hi_eff) + LEN_W'(HI_EXTRA);
        lo_len = LEN_W'(lo_eff) + LEN_W'(LO_EXTRA);
    end

    assign hold_val = regs_q[A_HOLD];

endmodule

// File: rtl/scl_phase_fsm.sv
// Clock phase sequencer.
// Runs one low or high SCL phase per accepted request and strobes its end.
// Phase lengths are latched into a down-counter when the request is taken.
// In a high phase the counter advances only on edges where SCL reads high.
// Assumes the bit engine alternates low and high requests.
module scl_phase_fsm
    import scl_timer_pkg::*;
#(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_low,
    input  logic             req_high,
    input  logic             scl_in,
    input  logic [LEN_W-1:0] hi_len,
    input  logic [LEN_W-1:0] lo_len,
    output logic             scl_oe,
    output logic             low_done,
    output logic             high_done,
    output logic             fall_evt
);

    phase_t           state_q;
    logic [LEN_W-1:0] cnt_q;

    // Marks the edge at which SCL is about to be pulled low.
    assign fall_evt = (state_q == PH_PARK_HI) && req_low;

    // Phase state, down-counter, SCL drive and end-of-phase strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PH_PARK_HI;
            cnt_q     <= '0;
            scl_oe    <= 1'b0;
            low_done  <= 1'b0;
            high_done <= 1'b0;
        end else begin
            low_done  <= 1'b0;
            high_done <= 1'b0;
            case (state_q)
                PH_PARK_HI: if (req_low) begin
                    state_q <= PH_LOW;
                    scl_oe  <= 1'b1;
                    cnt_q   <= lo_len - LEN_W'(1);
                end
                PH_LOW: if (cnt_q == '0) begin
                    state_q  <= PH_PARK_LO;
                    low_done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - LEN_W'(1);
                end
                PH_PARK_LO: if (req_high) begin
                    state_q <= PH_HIGH;
                    scl_oe  <= 1'b0;
                    cnt_q   <= hi_len - LEN_W'(1);
                end
                PH_HIGH: if (scl_in) begin
                    if (cnt_q == '0) begin
                        state_q   <= PH_PARK_HI;
                        high_done <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - LEN_W'(1);
                    end
                end
                default: state_q <= PH_PARK_HI;
            endcase
        end
    end

endmodule

// File: rtl/sda_hold_gate.sv
// SDA hold gate.
// Registers the SDA drive request. After each falling SCL edge it freezes
// the output for the programmed number of reference clocks, so data stays
// stable through the hold time. A new falling edge restarts the window.
module sda_hold_gate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_evt,
    input  logic [CNT_W-1:0] hold_val,
    input  logic             sda_req,
    output logic             sda_oe
);

    logic [CNT_W-1:0] wait_q;

    // Hold window counter and the gated SDA drive register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            sda_oe <= 1'b0;
        end else if (fall_evt) begin
            wait_q <= hold_val;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - CNT_W'(1);
        end else begin
            sda_oe <= sda_req;
        end
    end

endmodule

// File: rtl/scl_timer.sv
// SCL timing generator top.
// Ties the count registers, the phase sequencer and the SDA hold gate
// together. Outputs are open-drain enables (1 pulls the line low).
// scl_in must reflect the wired SCL level, including any slave hold.
module scl_timer
    import scl_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_on,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        speed_sel,
    input  logic              req_low,
    input  logic              req_high,
    input  logic              sda_req,
    input  logic              scl_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              low_done,
    output logic              high_done
);

    localparam int LEN_W = CNT_W + 2;

    logic [LEN_W-1:0] hi_len, lo_len;
    logic [CNT_W-1:0] hold_val;
    logic             fall_evt;

    scl_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_on    (ctl_on),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .speed_sel (speed_sel),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .hold_val  (hold_val)
    );

    scl_phase_fsm #(.LEN_W(LEN_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_low   (req_low),
        .req_high  (req_high),
        .scl_in    (scl_in),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .scl_oe    (scl_oe),
        .low_done  (low_done),
        .high_done (high_done),
        .fall_evt  (fall_evt)
    );

    sda_hold_gate #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .hold_val (hold_val),
        .sda_req  (sda_req),
        .sda_oe   (sda_oe)
    );

endmodule

// File: rtl/scl_timer_chk.sv
// Port-level properties of the SCL timer, attached by bind.
module scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic low_done,
    input logic high_done
);

    // R4: a low phase can only end while SCL is still pulled low.
    p_low_end_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_done |-> scl_oe);

    // R4: the low phase end strobe lasts one cycle.
    p_low_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_done |=> !low_done);

    // R5: a high phase can only end with SCL released.
    p_high_end_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        high_done |-> !scl_oe);

    // R5: the high phase end strobe lasts one cycle.
    p_high_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        high_done |=> !high_done);

    // R9: SDA does not move at the edge that pulls SCL low.
    p_sda_frozen_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $stable(sda_oe));

    // R11: both phase strobes never appear together.
    p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_done, high_done}));

endmodule

bind scl_timer scl_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .low_done  (low_done),
    .high_done (high_done)
);

// File: tb/sim_scl_timer.sv
`timescale 1ns/1ps
module sim_scl_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_on = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  speed_sel = 2'b01;
    logic        req_low = 1'b0;
    logic        req_high = 1'b0;
    logic        sda_req = 1'b0;
    logic        scl_in;
    logic        scl_oe, sda_oe, low_done, high_done;
    int          st_rem = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          shadow [5];

    always #2.5 clk = ~clk;

    // Wired SCL: pulled low by the block or by a slave that stretches.
    assign scl_in = !scl_oe && (st_rem == 0);

    scl_timer u0 (
        .clk(clk), .rst_n(rst_n), .ctl_on(ctl_on), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .speed_sel(speed_sel),
        .req_low(req_low), .req_high(req_high), .sda_req(sda_req),
        .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .low_done(low_done), .high_done(high_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int exp_lo(input logic [1:0] spd);
        return eff(spd == 2'b01 ? shadow[1] : shadow[3]) + 1;
    endfunction

    function automatic int exp_hi(input logic [1:0] spd);
        return eff(spd == 2'b01 ? shadow[0] : shadow[2]) + 3;
    endfunction

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        tick();
        wr_en = 1'b0;
        if (!ctl_on) shadow[a] = d;
    endtask

    // One full clock bit: low phase with SDA change, then high phase.
    task automatic run_bit(input logic [1:0] spd, input int stretch, input string tag);
        int lo_at = 0;
        int sda_at = 0;
        int hi_at = 0;
        logic start_sda;
        speed_sel = spd;
        start_sda = sda_oe;
        sda_req = ~sda_oe;
        req_low = 1'b1;
        tick();
        req_low = 1'b0;
        check(scl_oe == 1'b1, {tag, " R4 scl driven"}, int'(scl_oe), 1);
        for (int n = 1; n < 2000; n++) begin
            tick();
            if (lo_at == 0 && low_done) lo_at = n;
            if (sda_at == 0 && sda_oe != start_sda) sda_at = n;
            if (lo_at != 0 && sda_at != 0) break;
        end
        check(lo_at == exp_lo(spd), {tag, " R4 R2 low length"}, lo_at, exp_lo(spd));
        check(sda_at == shadow[4] + 1, {tag, " R9 hold"}, sda_at, shadow[4] + 1);
        check(scl_oe == 1'b1, {tag, " R4 parked low"}, int'(scl_oe), 1);
        st_rem = stretch;
        req_high = 1'b1;
        tick();
        req_high = 1'b0;
        check(scl_oe == 1'b0, {tag, " R5 released"}, int'(scl_oe), 0);
        for (int n = 1; n < 2000; n++) begin
            tick();
            if (st_rem > 0) st_rem--;
            if (high_done) begin hi_at = n; break; end
        end
        check(hi_at == exp_hi(spd) + stretch, {tag, " R5 R6 high length"},
              hi_at, exp_hi(spd) + stretch);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 5; i++) shadow[i] = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state.
        check({scl_oe, sda_oe, low_done, high_done} == 4'b0, "R1 reset outputs",
              int'({scl_oe, sda_oe, low_done, high_done}), 0);
        // R11: high request in clock-high idle is ignored.
        req_high = 1'b1; tick(); req_high = 1'b0;
        repeat (5) begin
            tick();
            check(!high_done && !scl_oe, "R11 stray high request", int'({high_done, scl_oe}), 0);
        end
        // R1 R7: reset counts are zero, clamped to one.
        run_bit(2'b01, 0, "R1 R7 defaults");
        // R2: program distinct pairs, check both speeds.
        wr(0, 7); wr(1, 9); wr(2, 2); wr(3, 4); wr(4, 3);
        ctl_on = 1'b1;
        run_bit(2'b01, 0, "R2 R8 std");
        run_bit(2'b10, 0, "R2 R8 fast");
        // R8: unused speed codes act as fast.
        run_bit(2'b00, 0, "R8 code00");
        run_bit(2'b11, 1, "R8 code11");
        // R3: writes while enabled are ignored.
        wr(1, 40); wr(4, 20);
        run_bit(2'b01, 0, "R3 locked");
        // R6: long stretch.
        run_bit(2'b10, 6, "R6 stretch");
        // Hold expiry on the same edge as low end (R9 with R4).
        ctl_on = 1'b0;
        wr(1, 5); wr(4, 5);
        ctl_on = 1'b1;
        run_bit(2'b01, 0, "R4 R9 coincide");
        // R10: outside the window SDA follows after one cycle.
        repeat (8) tick();
        sda_req = ~sda_oe;
        tick();
        check(sda_oe == sda_req, "R10 follow", int'(sda_oe), int'(sda_req));
        // R11: high request during low phase, low request when parked low.
        begin
            int lo_at = 0;
            speed_sel = 2'b01;
            req_low = 1'b1; tick(); req_low = 1'b0;
            req_high = 1'b1; tick(); req_high = 1'b0;
            for (int n = 2; n < 200; n++) begin
                tick();
                if (low_done) begin lo_at = n; break; end
            end
            check(lo_at == exp_lo(2'b01), "R11 high during low", lo_at, exp_lo(2'b01));
            req_low = 1'b1; tick(); req_low = 1'b0;
            repeat (4) begin
                tick();
                check(!low_done && scl_oe, "R11 stray low request",
                      int'({low_done, scl_oe}), 1);
            end
            req_high = 1'b1; tick(); req_high = 1'b0;
            for (int n = 0; n < 200; n++) begin
                tick();
                if (high_done) break;
            end
        end
        // R2 R7: random programming with a few zero counts.
        for (int it = 0; it < 40; it++) begin
            ctl_on = 1'b0;
            for (int a = 0; a < 5; a++) wr(a, int'($urandom_range(0, 12)));
            ctl_on = 1'b1;
            run_bit(2'($urandom_range(0, 3)), int'($urandom_range(0, 3)), "R2 R7 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule